// File: doc/BRIEF.md
# DMA Channel Cycle Sequencer

This block is the control engine of one DMA channel. When a peripheral request arrives, it reads a channel configuration word from one of two descriptors, primary or alternate. It decodes the cycle mode, the transfer count and the arbitration exponent from that word. It then runs the cycle as a series of bursts. Each burst waits for a grant from an external arbiter. The burst then issues transfer strobes, each completed by an acknowledge. After a burst the channel gives the bus back and asks for it again.

Before each arbitration the sequencer writes the number of outstanding transfers back into the descriptor. When the cycle ends, it marks the descriptor as stopped and pulses `done`. In ping-pong mode it then moves on to the other descriptor. It keeps alternating until it reads a descriptor that no longer asks for ping-pong. Address generation, the bus protocol and priority between channels belong to other blocks.

States: IDLE (wait for a pending request), LOAD (read descriptor), WBACK (write remaining count), ARB (request bus), XFER (strobe transfers), FIN (close descriptor, pulse done), ERR (invalid mode, held until reset). Transitions: IDLE→LOAD on a pending request; LOAD→IDLE on stop mode; LOAD→ERR on an unused mode; LOAD→WBACK on a run mode; WBACK→ARB always; ARB→XFER on a granted request; XFER→WBACK when a burst fills with transfers still left; XFER→FIN on the final acknowledge; FIN→LOAD in ping-pong mode (other descriptor); FIN→IDLE otherwise.

Top module: `dma_chan_seq`

## Requirements
- R1: The configuration word is laid out as follows: bits [2:0] hold the mode, bit 3 holds a burst flag, bits [13:4] hold N (the transfer count minus one), and bits [17:14] hold the exponent E. Every write-back keeps bit 3 and bits [17:14] exactly as they were read.
- R2: Mode 0 (stop) means no transfer takes place. No write-back happens and `done` does not pulse. The channel returns to IDLE and accepts a later request.
- R3: Modes 4 to 7 raise `err`, which stays high until reset. While `err` is high the channel makes no bus request and no transfer, even when new requests arrive.
- R4: In mode 1 (basic), each arbitration needs a request pulse that was seen since the previous grant. Without one, `arb_req` stays low and the cycle stalls.
- R5: In mode 2 (auto), the channel raises `arb_req` at every arbitration on its own, so one request pulse carries the whole cycle to completion.
- R6: A count field of N produces exactly N+1 acknowledged transfers. The full range is 1 to 1024 transfers.
- R7: A burst holds 2^E transfers for E from 0 to 9, and 1024 transfers for E of 10 or more. The last burst is shorter when fewer transfers remain. Each burst follows exactly one grant.
- R8: Before each arbitration, `desc_wr` writes the remaining transfer count minus one into bits [13:4]. The write goes to the descriptor selected by `desc_sel` (0 = primary, 1 = alternate), and bits [2:0] keep the mode.
- R9: After the final transfer, `done` is high for exactly one cycle. In that same cycle the descriptor is written back with mode 0 and count field 0.
- R10: In mode 3 (ping-pong), a finished cycle on one descriptor loads the other one. Alternation ends when a loaded descriptor is in mode 0. It also ends after a cycle whose descriptor is in mode 1 or 2.
- R11: `xfer_stb` stays high until `xfer_ack`, and each acknowledged strobe counts as one transfer. `xfer_stb` and `arb_req` are never high together.
- R12: After reset every output is low, and the first descriptor read selects the primary descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Peripheral request; each high cycle registers a pending request |
| arb_req | output | 1 | Bus request to the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter, taken while arb_req is high |
| desc_sel | output | 1 | Descriptor select: 0 primary, 1 alternate |
| desc_rd | output | 1 | Descriptor read; desc_rdata is sampled in this cycle |
| desc_rdata | input | 18 | Configuration word of the selected descriptor |
| desc_wr | output | 1 | Descriptor write-back strobe |
| desc_wdata | output | 18 | Configuration word written back |
| xfer_stb | output | 1 | Transfer strobe, held until acknowledged |
| xfer_ack | input | 1 | Transfer acknowledge |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| err | output | 1 | Sticky flag for an unused mode |

## Verification
Auto mode is swept over every exponent from 0 to 11 and several small counts. This separates full bursts from short tail bursts, and shows the cap at 1024 once E passes 9. Two large cases (1024 transfers with E of 9 and with E of 15) cover the top of the count range and the single unbroken burst. Basic mode is driven with widely spaced request pulses, so a stall between bursts can be told apart from an auto-style run. Ping-pong runs with the request held high: one pair of descriptors both in ping-pong mode, and one pair where the alternate is in basic mode. These show the hand-off both ending on a stopped descriptor and ending after a single-cycle descriptor, even when the host refills the primary.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MD_STOP  = 3'd0;
    localparam logic [MODE_W-1:0] MD_BASIC = 3'd1;
    localparam logic [MODE_W-1:0] MD_AUTO  = 3'd2;
    localparam logic [MODE_W-1:0] MD_PPONG = 3'd3;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_WBACK = 3'd2,
        S_ARB   = 3'd3,
        S_XFER  = 3'd4,
        S_FIN   = 3'd5,
        S_ERR   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
    import dma_seq_pkg::*;
#(
    parameter  int CNT_W  = 10,
    parameter  int REXP_W = 4,
    localparam int CFG_W  = MODE_W + 1 + CNT_W + REXP_W
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [MODE_W-1:0] mode,
    output logic              is_stop,
    output logic              is_run,
    output logic [CNT_W:0]    total,
    output logic [CNT_W:0]    blen
);

    localparam int CNT_LO  = MODE_W + 1;
    localparam int REXP_LO = CNT_LO + CNT_W;

    logic [CNT_W-1:0]  nm1;
    logic [REXP_W-1:0] rexp;
    logic [CNT_W:0]    pow_tab [CNT_W+1];

    assign mode = cfg[MODE_W-1:0];
    assign nm1  = cfg[CNT_LO +: CNT_W];
    assign rexp = cfg[REXP_LO +: REXP_W];

    // power-of-two burst sizes, one entry per exponent up to the count cap
    for (genvar g = 0; g <= CNT_W; g++) begin : g_pow
        assign pow_tab[g] = (CNT_W+1)'(1) << g;
    end

    always_comb begin
        is_stop = (mode == MD_STOP);
        is_run  = (mode == MD_BASIC) || (mode == MD_AUTO) || (mode == MD_PPONG);
        total   = {1'b0, nm1} + (CNT_W+1)'(1);
        blen    = pow_tab[CNT_W];
        for (int i = 0; i < CNT_W; i++) begin
            if (rexp == REXP_W'(i)) blen = pow_tab[i];
        end
    end

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
    parameter int CNT_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CNT_W:0] total,
    input  logic [CNT_W:0] blen,
    input  logic           burst_clr,
    input  logic           step,
    output logic [CNT_W:0] rem,
    output logic           last,
    output logic           burst_end
);

    logic [CNT_W:0] rem_q;
    logic [CNT_W:0] blen_q;
    logic [CNT_W:0] bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            blen_q <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            rem_q  <= total;
            blen_q <= blen;
            bcnt_q <= '0;
        end else if (burst_clr) begin
            bcnt_q <= '0;
        end else if (step) begin
            rem_q  <= rem_q - (CNT_W+1)'(1);
            bcnt_q <= bcnt_q + (CNT_W+1)'(1);
        end
    end

    assign rem       = rem_q;
    assign last      = (rem_q == (CNT_W+1)'(1));
    assign burst_end = ((bcnt_q + (CNT_W+1)'(1)) == blen_q);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter  int CNT_W  = 10,
    parameter  int REXP_W = 4,
    localparam int CFG_W  = MODE_W + 1 + CNT_W + REXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    output logic             arb_req,
    input  logic             arb_gnt,
    output logic             desc_sel,
    output logic             desc_rd,
    input  logic [CFG_W-1:0] desc_rdata,
    output logic             desc_wr,
    output logic [CFG_W-1:0] desc_wdata,
    output logic             xfer_stb,
    input  logic             xfer_ack,
    output logic             done,
    output logic             err
);

    localparam int CNT_LO = MODE_W + 1;

    seq_state_t        state_q, state_d;
    logic              sel_q, pend_q, err_q;
    logic [CFG_W-1:0]  word_q;
    logic [MODE_W-1:0] dec_mode;
    logic              dec_stop, dec_run;
    logic [CNT_W:0]    dec_total, dec_blen;
    logic [CNT_W:0]    rem;
    logic              last, burst_end;
    logic              want_bus, take_gnt, take_ack;
    logic [CNT_W-1:0]  rem_field;

    dma_cfg_decode #(.CNT_W(CNT_W), .REXP_W(REXP_W)) u_dec (
        .cfg     (desc_rdata),
        .mode    (dec_mode),
        .is_stop (dec_stop),
        .is_run  (dec_run),
        .total   (dec_total),
        .blen    (dec_blen)
    );

    assign want_bus = pend_q || (word_q[MODE_W-1:0] == MD_AUTO);
    assign take_gnt = (state_q == S_ARB) && want_bus && arb_gnt;
    assign take_ack = (state_q == S_XFER) && xfer_ack;

    dma_xfer_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == S_LOAD),
        .total     (dec_total),
        .blen      (dec_blen),
        .burst_clr (take_gnt),
        .step      (take_ack),
        .rem       (rem),
        .last      (last),
        .burst_end (burst_end)
    );

    assign rem_field = CNT_W'(rem - (CNT_W+1)'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (pend_q) state_d = S_LOAD;
            S_LOAD: begin
                if (dec_stop)      state_d = S_IDLE;
                else if (!dec_run) state_d = S_ERR;
                else               state_d = S_WBACK;
            end
            S_WBACK: state_d = S_ARB;
            S_ARB:   if (take_gnt) state_d = S_XFER;
            S_XFER: begin
                if (take_ack) begin
                    if (last)           state_d = S_FIN;
                    else if (burst_end) state_d = S_WBACK;
                end
            end
            S_FIN: begin
                if (word_q[MODE_W-1:0] == MD_PPONG) state_d = S_LOAD;
                else                                state_d = S_IDLE;
            end
            S_ERR:   state_d = S_ERR;
            default: state_d = S_IDLE;
        endcase
    end

    // channel bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
            word_q <= '0;
        end else begin
            if (req)
                pend_q <= 1'b1;
            else if (take_gnt || (state_q == S_LOAD && dec_stop))
                pend_q <= 1'b0;

            if (state_q == S_LOAD) begin
                word_q <= desc_rdata;
                if (dec_stop) sel_q <= 1'b0;
                if (!dec_stop && !dec_run) err_q <= 1'b1;
            end

            if (state_q == S_FIN) begin
                if (word_q[MODE_W-1:0] == MD_PPONG) sel_q <= ~sel_q;
                else                                sel_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        arb_req    = 1'b0;
        desc_rd    = 1'b0;
        desc_wr    = 1'b0;
        desc_wdata = word_q;
        xfer_stb   = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_LOAD:  desc_rd = 1'b1;
            S_WBACK: begin
                desc_wr = 1'b1;
                desc_wdata[CNT_LO +: CNT_W] = rem_field;
            end
            S_ARB:   arb_req = want_bus;
            S_XFER:  xfer_stb = 1'b1;
            S_FIN: begin
                desc_wr = 1'b1;
                done    = 1'b1;
                desc_wdata[CNT_LO +: CNT_W] = '0;
                desc_wdata[MODE_W-1:0]      = MD_STOP;
            end
            default: ;
        endcase
    end

    assign desc_sel = sel_q;
    assign err      = err_q;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CFG_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_req,
    input logic             desc_rd,
    input logic             desc_wr,
    input logic [CFG_W-1:0] desc_wdata,
    input logic             xfer_stb,
    input logic             xfer_ack,
    input logic             done,
    input logic             err
);

    a_r11_stb_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !xfer_ack) |=> xfer_stb);

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_stb && arb_req));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (desc_wr && desc_wdata[2:0] == 3'd0));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!xfer_stb && !arb_req && !done));

    a_r8_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_rd && desc_wr));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_req    (arb_req),
    .desc_rd    (desc_rd),
    .desc_wr    (desc_wr),
    .desc_wdata (desc_wdata),
    .xfer_stb   (xfer_stb),
    .xfer_ack   (xfer_ack),
    .done       (done),
    .err        (err)
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        arb_req, arb_gnt = 1'b0;
    logic        desc_sel, desc_rd, desc_wr;
    logic [17:0] desc_rdata, desc_wdata;
    logic        xfer_stb, xfer_ack = 1'b0;
    logic        done, err;

    logic [17:0] mem [2];
    int          tests = 0, fails = 0, cyc = 0;
    int          nx, nb, nw, ndone, nrd;
    int          bursts [64];
    logic [17:0] wlog [64];

    always #10 clk = ~clk;

    assign desc_rdata = mem[desc_sel];

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .arb_req(arb_req), .arb_gnt(arb_gnt),
        .desc_sel(desc_sel), .desc_rd(desc_rd), .desc_rdata(desc_rdata),
        .desc_wr(desc_wr), .desc_wdata(desc_wdata), .xfer_stb(xfer_stb),
        .xfer_ack(xfer_ack), .done(done), .err(err)
    );

    // arbiter, target and descriptor store, all acting away from the active edge
    always @(negedge clk) begin
        if (desc_wr) begin
            mem[desc_sel] = desc_wdata;
            if (nw < 64) wlog[nw] = desc_wdata;
            nw++;
        end
        if (desc_rd) nrd++;
        if (done) ndone++;
        if (arb_req && !arb_gnt) begin
            arb_gnt = 1'b1;
            if (nb < 64) bursts[nb] = 0;
            nb++;
        end else arb_gnt = 1'b0;
        if (xfer_stb && !xfer_ack) begin
            xfer_ack = 1'b1;
            nx++;
            if (nb >= 1 && nb <= 64) bursts[nb-1]++;
        end else xfer_ack = 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [17:0] mkcfg(int md, int n, int e, int f);
        return {4'(e), 10'(n), 1'(f), 3'(md)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        nx = 0; nb = 0; nw = 0; ndone = 0; nrd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_log();
    endtask

    task automatic pulse_req();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input int k);
        for (int i = 0; i < 6000 && ndone < k; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic run_auto(input int n, input int e);
        int rem, bl, k, expb;
        mem[0] = mkcfg(2, n, e, 1);
        clr_log();
        pulse_req();
        wait_done(1);
        chk(nx == n + 1, "R6 transfer count", nx, n + 1);
        chk(ndone == 1, "R5 single request completes", ndone, 1);
        bl = (e >= 10) ? 1024 : (1 << e);
        rem = n + 1;
        k = 0;
        expb = 0;
        while (rem > 0) begin
            int sz;
            sz = (rem < bl) ? rem : bl;
            if (k < 64) begin
                if (bursts[k] != sz) chk(0, "R7 burst size", bursts[k], sz);
                if (wlog[k][13:4] != 10'(rem - 1)) chk(0, "R8 write-back count", int'(wlog[k][13:4]), rem - 1);
                if (wlog[k][2:0] != 3'd2) chk(0, "R8 write-back mode", int'(wlog[k][2:0]), 2);
                if (wlog[k][17:14] != 4'(e) || wlog[k][3] != 1'b1)
                    chk(0, "R1 preserved fields", int'(wlog[k][17:14]), e);
            end
            rem -= sz;
            k++;
            expb++;
        end
        chk(nb == expb, "R7 burst count", nb, expb);
        chk(nw == expb + 1, "R8 write-back count", nw, expb + 1);
        chk(mem[0] == mkcfg(0, 0, e, 1), "R9 closed descriptor", int'(mem[0]), int'(mkcfg(0, 0, e, 1)));
    endtask

    initial begin
        mem[0] = '0;
        mem[1] = '0;
        do_reset();
        @(negedge clk);
        chk({arb_req, desc_rd, desc_wr, xfer_stb, done, err} == 6'b0, "R12 reset outputs",
            int'({arb_req, desc_rd, desc_wr, xfer_stb, done, err}), 0);
        chk(desc_sel == 1'b0, "R12 primary select", int'(desc_sel), 0);

        // auto-request sweep over exponents and counts
        for (int e = 0; e < 12; e++) begin
            run_auto(0, e);
            run_auto(1, e);
            run_auto(2, e);
            run_auto(5, e);
            run_auto(8, e);
            run_auto(15, e);
        end
        run_auto(1023, 9);
        run_auto(1023, 15);

        // basic mode: one burst per request pulse
        mem[0] = mkcfg(1, 5, 1, 0);
        clr_log();
        pulse_req();
        repeat (40) @(negedge clk);
        chk(nb == 1 && nx == 2, "R4 first burst only", nx, 2);
        chk(arb_req == 1'b0, "R4 no request without pulse", int'(arb_req), 0);
        pulse_req();
        repeat (40) @(negedge clk);
        chk(nb == 2 && nx == 4, "R4 second burst", nx, 4);
        chk(ndone == 0, "R4 not yet done", ndone, 0);
        pulse_req();
        repeat (40) @(negedge clk);
        chk(nx == 6 && ndone == 1, "R4 cycle complete", nx, 6);
        chk(wlog[1][13:4] == 10'd3, "R8 basic remaining", int'(wlog[1][13:4]), 3);

        // stop mode: nothing happens, channel stays usable
        mem[0] = mkcfg(0, 3, 0, 0);
        clr_log();
        pulse_req();
        repeat (20) @(negedge clk);
        chk(nx == 0 && nw == 0 && ndone == 0, "R2 stop idle", nx + nw + ndone, 0);
        chk(err == 1'b0, "R2 no error", int'(err), 0);
        mem[0] = mkcfg(2, 0, 0, 0);
        pulse_req();
        wait_done(1);
        chk(nx == 1, "R2 accepts later request", nx, 1);

        // unused mode: sticky error, no activity
        mem[0] = mkcfg(6, 2, 0, 0);
        clr_log();
        pulse_req();
        repeat (20) @(negedge clk);
        chk(err == 1'b1, "R3 error raised", int'(err), 1);
        mem[0] = mkcfg(2, 2, 0, 0);
        pulse_req();
        repeat (30) @(negedge clk);
        chk(nx == 0 && nb == 0, "R3 halted", nx + nb, 0);
        chk(err == 1'b1, "R3 error held", int'(err), 1);
        do_reset();
        chk(err == 1'b0, "R12 reset clears error", int'(err), 0);

        // ping-pong: both descriptors alternate until a stopped one is read
        mem[0] = mkcfg(3, 2, 0, 0);
        mem[1] = mkcfg(3, 1, 3, 0);
        clr_log();
        @(negedge clk);
        req = 1'b1;
        wait_done(2);
        repeat (20) @(negedge clk);
        req = 1'b0;
        repeat (20) @(negedge clk);
        chk(ndone == 2, "R10 two cycles", ndone, 2);
        chk(nx == 5, "R10 transfers", nx, 5);
        chk(nb == 4 && bursts[3] == 2, "R10 alternate burst", bursts[3], 2);
        chk(mem[0][2:0] == 3'd0 && mem[1][2:0] == 3'd0, "R10 both closed",
            int'({mem[1][2:0], mem[0][2:0]}), 0);

        // ping-pong handing off to a basic descriptor ends the alternation
        do_reset();
        mem[0] = mkcfg(3, 0, 0, 0);
        mem[1] = mkcfg(1, 0, 0, 0);
        clr_log();
        @(negedge clk);
        req = 1'b1;
        wait (ndone >= 1);
        mem[0] = mkcfg(3, 0, 0, 0);
        req = 1'b0;
        repeat (60) @(negedge clk);
        chk(ndone == 2 && nx == 2, "R10 alternate cycle ran", nx, 2);
        chk(nrd == 2, "R10 no further load", nrd, 2);
        chk(mem[1][2:0] == 3'd0, "R9 alternate closed", int'(mem[1][2:0]), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule